// File: doc/BRIEF.md
# Full-Duplex SPI Master Transfer Engine

This block runs one SPI exchange at a time as the bus master. A caller hands it a parallel word and a set of per-transfer settings: the number of bits, which end of the word goes first, the serial-clock edge that moves the outgoing line, the edge that captures the incoming line, a clock divisor and a slave-select mask. The engine derives the serial clock from the system clock, drives the outgoing bit stream, captures the incoming stream, and returns the received word together with a single-cycle completion pulse. One register holds the word. Outgoing bits are read from it and incoming bits are written back into it, so the exchange is full duplex.

A transfer request is a valid/ready handshake. `start_valid` is qualified by `start_ready`, which is high only while the engine is idle. A request is taken on the rising clock edge where both are high, and every setting is latched on that edge. `start_valid` does not have to be held. If it is raised while `start_ready` is low, the request is dropped rather than queued. The received word has no back-pressure. It is announced by the `done` pulse and held on `rx_word` until the next completion.

Top module: `spi_xfer_engine`

## Requirements
- R1: `start_ready` is high exactly while `busy` is low. A request accepted on one clock edge makes `busy` high and `start_ready` low from the next cycle on. After reset the engine is idle, with `sck` low and every `ss_n` line high.
- R2: While a transfer runs, a request on `start_valid` is not accepted, and changing any setting input has no effect on that transfer's serial streams, select line or received word.
- R3: A transfer moves N bits, where N equals `word_len`, and a `word_len` of 0 means 32. It produces exactly N rising and N falling `sck` edges, and `busy` stays high for 2·N·H clock cycles.
- R4: The effective divisor D is `sck_div` clamped to the range 2 to 128. H equals D/2 rounded down. Every `sck` high or low level during a transfer lasts H clock cycles, the first low level starts on the accepting edge, and `sck` is low whenever the engine is idle.
- R5: With `lsb_first`=1, transmit bit j goes out j-th (counting from 0) and the j-th received bit lands in `rx_word` bit j. With `lsb_first`=0, transmit bit N-1-j goes out j-th and the j-th received bit lands in bit N-1-j. Bits N and above of `rx_word` read 0.
- R6: The first outgoing bit is on `mosi` from the cycle after acceptance. With `launch_fall`=1, `mosi` changes only on falling `sck` edges 1..N-1. With `launch_fall`=0, it changes only on rising edges 2..N. In both cases, a slave that samples on the opposite edge sees all N bits in order.
- R7: With `sample_fall`=0, `miso` is captured on each of the N rising edges. With `sample_fall`=1, it is captured on each of the N falling edges, the last one coinciding with the end of the transfer.
- R8: `done` is high for exactly one cycle, which is the first cycle with `busy` low after a transfer. `rx_word` takes the new value in that cycle and holds it until the next `done`.
- R9: At acceptance, the lowest set bit of `ss_mask` selects one active-low `ss_n` line. That line is low for exactly the cycles in which `busy` is high, all other lines stay high, and a zero mask drives no line low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Transfer request, qualified by start_ready |
| start_ready | output | 1 | High while idle; a request is taken when both are high |
| tx_word | input | MAX_LEN | Word to send, latched at acceptance |
| word_len | input | $clog2(MAX_LEN) | Bits per transfer, 0 selects MAX_LEN |
| lsb_first | input | 1 | 1 sends the low end of the word first |
| launch_fall | input | 1 | 1 moves mosi on falling sck edges, 0 on rising |
| sample_fall | input | 1 | 1 captures miso on falling sck edges, 0 on rising |
| sck_div | input | DIV_W | System clocks per sck period, clamped to 2..128 |
| ss_mask | input | SS_N | Candidate slaves; the lowest set bit is used |
| busy | output | 1 | High while a transfer runs |
| done | output | 1 | One-cycle completion pulse |
| rx_word | output | MAX_LEN | Received word, valid from done onward |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| ss_n | output | SS_N | Active-low slave selects |

## Verification
Some properties hold on every cycle and are checked there. The serial clock stays low while idle, at most one select line is low and it does not move mid-transfer, the handshake settings stay frozen while busy, the completion pulse coincides with the fall of busy, and mosi moves only on the selected sck edge. At the last edge, every bit has been launched and N bits have been captured. Other behaviour can only be shown by the bench's scenarios. These are the actual bit placement for each order and edge combination, the exact level widths and cycle counts for each divisor including the clamped ones, and the received word returned by a slave model answering on the opposite edge. The bench sweeps every order and edge combination across several word lengths, including the zero code for 32. It also sweeps the divisor boundaries and select masks, and it pokes start requests and setting changes into running transfers.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  // Per-transfer bit ordering and edge selection, latched at acceptance.
  typedef struct packed {
    logic lsb_first;
    logic launch_fall;
    logic sample_fall;
  } bit_mode_t;

endpackage

// File: rtl/spi_eng_sckgen.sv
// Serial clock generator: half-period counter, edge strobes, end detection.
module spi_eng_sckgen #(
  parameter int CNT_W  = 6,
  parameter int HALF_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [HALF_W-1:0] half,
  input  logic [CNT_W-1:0]  n_bits,
  output logic              active,
  output logic              sck,
  output logic              rise_ev,
  output logic              fall_ev,
  output logic              last_ev
);

  logic [HALF_W-1:0] cnt;
  logic [CNT_W-1:0]  rise_cnt;
  logic              tick;

  assign tick    = active && (cnt == '0);
  assign rise_ev = tick && !sck;
  assign fall_ev = tick && sck;
  assign last_ev = fall_ev && (rise_cnt == n_bits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      sck      <= 1'b0;
      cnt      <= '0;
      rise_cnt <= '0;
    end else if (start) begin
      active   <= 1'b1;
      sck      <= 1'b0;
      cnt      <= half - 1'b1;
      rise_cnt <= '0;
    end else if (tick) begin
      cnt <= half - 1'b1;
      if (last_ev) begin
        active <= 1'b0;
        sck    <= 1'b0;
      end else begin
        sck <= !sck;
      end
      if (rise_ev) rise_cnt <= rise_cnt + 1'b1;
    end else if (active) begin
      cnt <= cnt - 1'b1;
    end
  end

  // R4
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sck);

  // R3
  rise_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (rise_cnt <= n_bits));

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !last_ev) |=> active);

endmodule

// File: rtl/spi_eng_shreg.sv
// Shared transmit/receive word with independent launch and capture pointers.
module spi_eng_shreg
  import spi_eng_pkg::*;
#(
  parameter int MAX_LEN = 32,
  parameter int CNT_W   = 6,
  localparam int IDX_W  = $clog2(MAX_LEN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [MAX_LEN-1:0] tx_word,
  input  logic [CNT_W-1:0]   n_bits,
  input  bit_mode_t          mode,
  input  logic               rise_ev,
  input  logic               fall_ev,
  input  logic               last_ev,
  input  logic               miso,
  output logic               mosi,
  output logic [MAX_LEN-1:0] rx_word,
  output logic               done
);

  logic [MAX_LEN-1:0] word_q;
  logic [MAX_LEN-1:0] word_nxt;
  logic [MAX_LEN-1:0] len_mask;
  logic [CNT_W-1:0]   tx_k;
  logic [CNT_W-1:0]   rx_k;
  logic               seen_rise;
  logic               launch;
  logic               sample;
  logic [IDX_W-1:0]   tx_pos;
  logic [IDX_W-1:0]   rx_pos;
  logic [IDX_W-1:0]   first_pos;

  // Serial position k maps to a word bit according to the bit order.
  function automatic logic [IDX_W-1:0] bit_pos(input logic [CNT_W-1:0] k,
                                               input logic [CNT_W-1:0] n,
                                               input logic lsb);
    logic [CNT_W-1:0] p;
    p = lsb ? k : (n - k - 1'b1);
    return p[IDX_W-1:0];
  endfunction

  assign first_pos = bit_pos('0, n_bits, mode.lsb_first);
  assign tx_pos    = bit_pos(tx_k, n_bits, mode.lsb_first);
  assign rx_pos    = bit_pos(rx_k, n_bits, mode.lsb_first);

  // The first launch-polarity edge is skipped when launching on rises:
  // the first bit was already placed at acceptance.
  assign launch = (tx_k < n_bits) &&
                  (mode.launch_fall ? (fall_ev && !last_ev) : (rise_ev && seen_rise));
  assign sample = (rx_k < n_bits) && (mode.sample_fall ? fall_ev : rise_ev);

  always_comb begin
    word_nxt = word_q;
    if (sample) word_nxt[rx_pos] = miso;
  end

  always_comb begin
    for (int i = 0; i < MAX_LEN; i++) len_mask[i] = (i < int'(n_bits));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q    <= '0;
      mosi      <= 1'b0;
      tx_k      <= '0;
      rx_k      <= '0;
      seen_rise <= 1'b0;
      rx_word   <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        word_q    <= tx_word;
        mosi      <= tx_word[first_pos];
        tx_k      <= CNT_W'(1);
        rx_k      <= '0;
        seen_rise <= 1'b0;
      end else begin
        word_q <= word_nxt;
        if (rise_ev) seen_rise <= 1'b1;
        if (launch) begin
          mosi <= word_q[tx_pos];
          tx_k <= tx_k + 1'b1;
        end
        if (sample) rx_k <= rx_k + 1'b1;
        if (last_ev) begin
          rx_word <= word_nxt & len_mask;
          done    <= 1'b1;
        end
      end
    end
  end

  // R6
  all_launched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_ev |-> (tx_k == n_bits));

  // R7
  all_sampled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_ev |-> ((rx_k + CNT_W'(sample)) == n_bits));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rx_word));

endmodule

// File: rtl/spi_eng_ssel.sv
// Lowest-set-bit slave pick, latched per transfer, driven active low.
module spi_eng_ssel #(
  parameter int SS_N = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            active,
  input  logic [SS_N-1:0] mask,
  output logic [SS_N-1:0] ss_n
);

  logic [SS_N-1:0] below;
  logic [SS_N-1:0] pick;
  logic [SS_N-1:0] sel_q;

  generate
    for (genvar i = 0; i < SS_N; i++) begin : g_pick
      if (i == 0) begin : g_first
        assign below[i] = 1'b0;
      end else begin : g_rest
        assign below[i] = below[i-1] || mask[i-1];
      end
      assign pick[i] = mask[i] && !below[i];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sel_q <= '0;
    else if (start) sel_q <= pick;
  end

  assign ss_n = ~(sel_q & {SS_N{active}});

  // R9
  ss_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ss_n));

  // R9
  ss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(ss_n));

endmodule

// File: rtl/spi_xfer_engine.sv
// SPI master transfer engine top: handshake, setting latch, sub-block wiring.
module spi_xfer_engine
  import spi_eng_pkg::*;
#(
  parameter int MAX_LEN = 32,
  parameter int SS_N    = 4,
  parameter int DIV_W   = 8,
  parameter int DIV_MIN = 2,
  parameter int DIV_MAX = 128,
  localparam int LEN_W  = $clog2(MAX_LEN),
  localparam int CNT_W  = $clog2(MAX_LEN + 1),
  localparam int HALF_W = $clog2(DIV_MAX / 2 + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_valid,
  output logic               start_ready,
  input  logic [MAX_LEN-1:0] tx_word,
  input  logic [LEN_W-1:0]   word_len,
  input  logic               lsb_first,
  input  logic               launch_fall,
  input  logic               sample_fall,
  input  logic [DIV_W-1:0]   sck_div,
  input  logic [SS_N-1:0]    ss_mask,
  output logic               busy,
  output logic               done,
  output logic [MAX_LEN-1:0] rx_word,
  output logic               sck,
  output logic               mosi,
  input  logic               miso,
  output logic [SS_N-1:0]    ss_n
);

  logic              accept;
  logic              busy_w;
  logic [CNT_W-1:0]  nb_in, nb_q, nb_use;
  logic [HALF_W-1:0] half_in, half_q, half_use;
  bit_mode_t         mode_in, mode_q, mode_use;
  logic [DIV_W-1:0]  div_clamped;
  logic              rise_ev, fall_ev, last_ev;

  assign start_ready = !busy_w;
  assign accept      = start_valid && start_ready;
  assign busy        = busy_w;

  always_comb begin
    nb_in = (word_len == '0) ? CNT_W'(MAX_LEN) : CNT_W'(word_len);
    if (sck_div < DIV_W'(DIV_MIN))      div_clamped = DIV_W'(DIV_MIN);
    else if (sck_div > DIV_W'(DIV_MAX)) div_clamped = DIV_W'(DIV_MAX);
    else                                div_clamped = sck_div;
    half_in             = HALF_W'(div_clamped >> 1);
    mode_in.lsb_first   = lsb_first;
    mode_in.launch_fall = launch_fall;
    mode_in.sample_fall = sample_fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nb_q   <= '0;
      half_q <= '0;
      mode_q <= '0;
    end else if (accept) begin
      nb_q   <= nb_in;
      half_q <= half_in;
      mode_q <= mode_in;
    end
  end

  // Settings take effect on the accepting edge itself, then come from the latch.
  assign nb_use   = accept ? nb_in   : nb_q;
  assign half_use = accept ? half_in : half_q;
  assign mode_use = accept ? mode_in : mode_q;

  spi_eng_sckgen #(
    .CNT_W (CNT_W),
    .HALF_W(HALF_W)
  ) u_sckgen (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (accept),
    .half   (half_use),
    .n_bits (nb_use),
    .active (busy_w),
    .sck    (sck),
    .rise_ev(rise_ev),
    .fall_ev(fall_ev),
    .last_ev(last_ev)
  );

  spi_eng_shreg #(
    .MAX_LEN(MAX_LEN),
    .CNT_W  (CNT_W)
  ) u_shreg (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (accept),
    .tx_word(tx_word),
    .n_bits (nb_use),
    .mode   (mode_use),
    .rise_ev(rise_ev),
    .fall_ev(fall_ev),
    .last_ev(last_ev),
    .miso   (miso),
    .mosi   (mosi),
    .rx_word(rx_word),
    .done   (done)
  );

  spi_eng_ssel #(
    .SS_N(SS_N)
  ) u_ssel (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept),
    .active(busy_w),
    .mask  (ss_mask),
    .ss_n  (ss_n)
  );

  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && !start_ready));

  // R2
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable({nb_q, half_q, mode_q}));

  // R8
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $fell(busy));

  // R8
  end_gives_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R6
  mosi_fall_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_q.launch_fall && !$stable(mosi) && !$past(accept)) |-> $fell(sck));

  // R6
  mosi_rise_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mode_q.launch_fall && !$stable(mosi) && !$past(accept)) |-> $rose(sck));

endmodule

// File: tb/spi_xfer_engine_bench.sv
module spi_xfer_engine_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_valid, start_ready;
  logic [31:0] tx_word;
  logic [4:0]  word_len;
  logic        lsb_first, launch_fall, sample_fall;
  logic [7:0]  sck_div;
  logic [3:0]  ss_mask;
  logic        busy, done;
  logic [31:0] rx_word;
  logic        sck, mosi, miso;
  logic [3:0]  ss_n;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  spi_xfer_engine u_spi_xfer_engine (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .tx_word(tx_word), .word_len(word_len), .lsb_first(lsb_first),
    .launch_fall(launch_fall), .sample_fall(sample_fall), .sck_div(sck_div),
    .ss_mask(ss_mask), .busy(busy), .done(done), .rx_word(rx_word),
    .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_xfer(input logic [31:0] tx, input logic [31:0] sl, input int len_field,
                          input bit lsb, input bit lf, input bit sf, input int div,
                          input logic [3:0] mask, input bit poke);
    int n, d, h, rises, falls, run, busy_cyc, bad_run, bad_edge, bad_ss, p;
    logic [31:0] exp_rx, exp_m, got_m;
    logic [3:0]  exp_sel;
    logic        prev_sck, prev_mosi, r, f;
    n = (len_field == 0) ? 32 : len_field;
    d = (div < 2) ? 2 : ((div > 128) ? 128 : div);
    h = d / 2;
    exp_rx = '0; exp_m = '0; got_m = '0;
    for (int k = 0; k < n; k++) begin
      p = lsb ? k : n - 1 - k;
      exp_rx[p] = sl[k];
      exp_m[k]  = tx[p];
    end
    exp_sel = '0;
    for (int i = 3; i >= 0; i--) if (mask[i]) exp_sel = 4'(1 << i);

    @(negedge clk);
    tx_word = tx; word_len = 5'(len_field); lsb_first = lsb; launch_fall = lf;
    sample_fall = sf; sck_div = 8'(div); ss_mask = mask; miso = sl[0];
    start_valid = 1'b1;
    check(start_ready == 1'b1, "R1", "ready before start", start_ready, 1);
    @(negedge clk);
    start_valid = 1'b0;
    check(busy == 1'b1 && start_ready == 1'b0, "R1", "busy/ready after accept",
          {busy, start_ready}, 2'b10);
    check(ss_n == ~exp_sel, "R9", "select line", ss_n, ~exp_sel);
    check(mosi == exp_m[0], "R6", "first mosi bit", mosi, exp_m[0]);
    rises = 0; falls = 0; run = 1; busy_cyc = 1; bad_run = 0; bad_edge = 0; bad_ss = 0;
    prev_sck = sck; prev_mosi = mosi;
    forever begin
      @(negedge clk);
      r = sck && !prev_sck;
      f = !sck && prev_sck;
      if (r) begin
        rises++;
        if (lf && rises <= 32) got_m[rises-1] = mosi;
        if (sf && rises >= 2 && rises <= n) miso = sl[rises-1];
      end
      if (f) begin
        falls++;
        if (!lf && falls <= 32) got_m[falls-1] = mosi;
        if (!sf && falls < n) miso = sl[falls];
      end
      if (mosi !== prev_mosi && !(lf ? f : r)) bad_edge++;
      if (r || f) begin
        if (run != h) bad_run++;
        run = 1;
      end else run++;
      if (busy) begin
        busy_cyc++;
        if (ss_n != ~exp_sel) bad_ss++;
      end
      if (poke && busy_cyc == 3) begin
        check(start_ready == 1'b0, "R2", "ready low while busy", start_ready, 0);
        start_valid = 1'b1; tx_word = ~tx; word_len = 5'(len_field + 3);
        lsb_first = ~lsb; launch_fall = ~lf; sample_fall = ~sf;
        sck_div = 8'(div + 6); ss_mask = ~mask;
      end else start_valid = 1'b0;
      prev_sck = sck; prev_mosi = mosi;
      if (done || !busy || busy_cyc > 20000) break;
    end
    start_valid = 1'b0;
    check(done == 1'b1, "R8", "done with busy fall", done, 1);
    check(rx_word == exp_rx, "R5", "received word", rx_word, exp_rx);
    check(got_m == exp_m, poke ? "R2" : "R6", "mosi stream", got_m, exp_m);
    check(rises == n && falls == n, "R3", "sck edge count", rises * 256 + falls, n * 256 + n);
    check(busy_cyc == 2 * n * h, "R3", "busy cycles", busy_cyc, 2 * n * h);
    check(bad_run == 0, "R4", "sck level widths", bad_run, 0);
    check(bad_edge == 0, "R6", "mosi change edges", bad_edge, 0);
    check(bad_ss == 0, "R9", "select held", bad_ss, 0);
    check(sck == 1'b0, "R4", "sck low at end", sck, 0);
    @(negedge clk);
    check(done == 1'b0, "R8", "done single cycle", done, 0);
    check(rx_word == exp_rx, "R8", "received word held", rx_word, exp_rx);
    check(ss_n == 4'hF, "R9", "selects released", ss_n, 4'hF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int idx, lv, dv;
    logic [31:0] t, s;
    rst_n = 1'b0; start_valid = 1'b0; tx_word = '0; word_len = '0; lsb_first = 1'b0;
    launch_fall = 1'b0; sample_fall = 1'b0; sck_div = 8'd2; ss_mask = '0; miso = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(start_ready == 1'b1 && busy == 1'b0 && done == 1'b0, "R1", "reset idle",
          {start_ready, busy, done}, 3'b100);
    check(sck == 1'b0, "R4", "reset sck", sck, 0);
    check(ss_n == 4'hF, "R9", "reset selects", ss_n, 4'hF);
    check(rx_word == '0, "R8", "reset rx word", rx_word, 0);

    idx = 0;
    for (int m = 0; m < 8; m++) begin
      for (int li = 0; li < 6; li++) begin
        for (int di = 0; di < 2; di++) begin
          case (li)
            0: lv = 1; 1: lv = 2; 2: lv = 3; 3: lv = 7; 4: lv = 8; default: lv = 0;
          endcase
          dv = di ? 5 : 2;
          t = 32'h5A3C_96E1 ^ (32'(idx) * 32'h01F3_A7C5);
          s = {t[12:0], t[31:13]} ^ 32'hC3A5_5A3C;
          run_xfer(t, s, lv, m[0], m[1], m[2], dv, 4'(idx + 1), (idx % 3) == 0);
          idx++;
        end
      end
    end

    for (int k = 0; k < 8; k++) begin
      case (k)
        0: dv = 0; 1: dv = 1; 2: dv = 3; 3: dv = 4;
        4: dv = 6; 5: dv = 128; 6: dv = 129; default: dv = 255;
      endcase
      t = 32'hF0E1_D2C3 + 32'(k) * 32'h1111_0101;
      s = ~t;
      run_xfer(t, s, 3, k[0], k[1], k[2], dv, 4'(k * 5), 1'b0);
    end

    run_xfer(32'h0000_0005, 32'h0000_0006, 3, 1'b0, 1'b0, 1'b1, 2, 4'b0000, 1'b0);
    run_xfer(32'h0000_0005, 32'h0000_0006, 3, 1'b1, 1'b1, 1'b0, 2, 4'b1000, 1'b0);
    run_xfer(32'h8000_0001, 32'hFFFF_FFFF, 0, 1'b0, 1'b1, 1'b1, 4, 4'b0110, 1'b1);
    run_xfer(32'hFFFF_FFFF, 32'h0000_0000, 31, 1'b1, 1'b0, 1'b0, 2, 4'b1111, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule